// File: doc/BRIEF.md
# Vectored Micro-Sequence Generator

This block serves instructions that the front end routes down the vector path rather than through the short or long hardware decoders. On a start strobe it captures a four-slot operation group built by the vector decode logic, together with a slot-valid mask and a starting address into an internal operation ROM. It first presents the captured group. After that it reads the ROM one word per accepted group and presents each word's four slots. The sequence stops once the group whose end bit is set has been accepted.

Every group leaves the block in the same four-slot format that the hardware decoders use. Each slot whose mask bit is clear is replaced by the NOP encoding, which is all zeros. A busy flag is high for as long as a sequence is in flight. The front end uses this flag to keep the other decode paths silent. The output follows a valid/ready handshake and moves on only when the consumer is ready.

The control is a three-state machine. `ST_IDLE` moves to `ST_FIRST` on a start strobe (the capture transition). `ST_FIRST` presents the captured group and moves to `ST_ROM` when that group is accepted (the hand-off transition). `ST_ROM` presents ROM words. When a word without the end bit is accepted, the machine stays in `ST_ROM` and the address steps by one (the step transition). When the word with the end bit is accepted, the machine returns to `ST_IDLE` (the finish transition). In every state, a cycle with `out_valid` high and `out_ready` low holds the state and the presented group.

Top module: `vseq_gen`

## Requirements
- R1: While reset is held and directly after it, `out_valid` and `busy` are low.
- R2: A start strobe seen in `ST_IDLE` at a clock edge makes the next cycle present the captured initial group, with `out_valid` and `busy` high. Slot s occupies bits [16s+15:16s], and every slot whose mask bit s is 0 reads as NOP (16'h0000).
- R3: Once the initial group is accepted, the next group is the ROM word at the captured start address. ROM word a has the op 16'h8000 | (a<<4) | s in slot s. Its mask enables slots 0 to (a mod 4), and the remaining slots read as NOP.
- R4: Each accepted ROM group that lacks the end bit is followed by the ROM word at the next address up.
- R5: While `out_valid` is high and `out_ready` is low, the presented group and `out_last` stay unchanged in the following cycle.
- R6: `out_last` is high exactly on ROM groups whose end bit is set, which are the words at addresses with a mod 8 = 7. In the cycle after such a group is accepted, `busy` and `out_valid` are low.
- R7: `busy` is high from the cycle after the start strobe until the final group is accepted.
- R8: A start strobe that arrives while `busy` is high is ignored, and the running sequence continues unchanged.
- R9: `out_valid` is never high unless `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a vectored sequence (honoured only when idle) |
| start_addr | input | 5 | ROM address of the first word after the initial group |
| start_ops | input | 64 | Initial group of four 16-bit operations from the vector decode logic |
| start_mask | input | 4 | Slot-valid mask for the initial group |
| out_valid | output | 1 | A group is presented |
| out_ready | input | 1 | Consumer accepts the presented group |
| out_ops | output | 64 | Presented group, with NOP in any unused slot |
| out_last | output | 1 | Presented group is the final group of the sequence |
| busy | output | 1 | Vector path owns the decode slot |

## Verification
A start strobe sampled at one rising edge shows up in the cycle that follows: at that point `out_valid`, `busy` and the padded initial group are all visible. Each group accepted at an edge is replaced by its successor by the next edge. The final acceptance clears `busy` one cycle later. The bench drives every input on the falling edge and reads the outputs on that same falling edge, halfway between two rising edges. It advances its own expected group only after a falling edge on which it had raised ready, so a stalled cycle is compared against the unchanged group.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_ROM   = 2'd2
    } vseq_state_e;
endpackage

// File: rtl/vseq_rom.sv
module vseq_rom #(
    parameter int OP_W   = 16,
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [SLOTS*OP_W-1:0] rd_ops,
    output logic [SLOTS-1:0]      rd_mask,
    output logic                  rd_end
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [OP_W-1:0] OP_TAG = OP_W'(1) << (OP_W - 1);

    logic [SLOTS*OP_W-1:0] ops_tbl  [DEPTH];
    logic [SLOTS-1:0]      mask_tbl [DEPTH];
    logic                  end_tbl  [DEPTH];

    // Contents are computed, one word per address.
    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        localparam int CNT = (a % 4) + 1;
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign ops_tbl[a][s*OP_W +: OP_W] = OP_TAG | (OP_W'(a) << 4) | OP_W'(s);
        end
        assign mask_tbl[a] = SLOTS'((1 << CNT) - 1);
        assign end_tbl[a]  = ((a % 8) == 7) || (a == DEPTH - 1);
    end

    assign rd_ops  = ops_tbl[addr];
    assign rd_mask = mask_tbl[addr];
    assign rd_end  = end_tbl[addr];
endmodule

// File: rtl/vseq_pad.sv
module vseq_pad #(
    parameter int OP_W  = 16,
    parameter int SLOTS = 4
) (
    input  logic [SLOTS*OP_W-1:0] raw_ops,
    input  logic [SLOTS-1:0]      mask,
    output logic [SLOTS*OP_W-1:0] ops
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign ops[s*OP_W +: OP_W] = mask[s] ? raw_ops[s*OP_W +: OP_W] : '0;
    end
endmodule

// File: rtl/vseq_fsm.sv
module vseq_fsm
    import vseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic out_ready,
    input  logic rom_end,
    output logic out_valid,
    output logic busy,
    output logic sel_rom,
    output logic load,
    output logic step,
    output logic seed
);
    vseq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_FIRST;
            ST_FIRST: if (out_ready) state_d = ST_ROM;
            ST_ROM:   if (out_ready && rom_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        busy      = 1'b0;
        sel_rom   = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        seed      = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_FIRST: begin
                out_valid = 1'b1;
                busy      = 1'b1;
                seed      = out_ready;
            end
            ST_ROM: begin
                out_valid = 1'b1;
                busy      = 1'b1;
                sel_rom   = 1'b1;
                step      = out_ready && !rom_end;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vseq_gen.sv
module vseq_gen #(
    parameter int OP_W   = 16,
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [SLOTS*OP_W-1:0] start_ops,
    input  logic [SLOTS-1:0]      start_mask,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SLOTS*OP_W-1:0] out_ops,
    output logic                  out_last,
    output logic                  busy
);
    localparam int GRP_W = SLOTS * OP_W;

    logic [GRP_W-1:0]  init_ops_q;
    logic [SLOTS-1:0]  init_mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [GRP_W-1:0]  rom_ops, raw_ops;
    logic [SLOTS-1:0]  rom_mask, raw_mask;
    logic              rom_end, sel_rom, load, step, seed;

    vseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .out_ready (out_ready),
        .rom_end   (rom_end),
        .out_valid (out_valid),
        .busy      (busy),
        .sel_rom   (sel_rom),
        .load      (load),
        .step      (step),
        .seed      (seed)
    );

    vseq_rom #(.OP_W(OP_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_rom (
        .addr    (addr_q),
        .rd_ops  (rom_ops),
        .rd_mask (rom_mask),
        .rd_end  (rom_end)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_ops_q  <= '0;
            init_mask_q <= '0;
            addr_q      <= '0;
        end else if (load) begin
            init_ops_q  <= start_ops;
            init_mask_q <= start_mask;
            addr_q      <= start_addr;
        end else if (step) begin
            addr_q      <= addr_q + 1'b1;
        end
    end

    assign raw_ops  = sel_rom ? rom_ops  : init_ops_q;
    assign raw_mask = sel_rom ? rom_mask : init_mask_q;

    vseq_pad #(.OP_W(OP_W), .SLOTS(SLOTS)) u_pad (
        .raw_ops (raw_ops),
        .mask    (raw_mask),
        .ops     (out_ops)
    );

    assign out_last = sel_rom && rom_end;

    logic unused_seed;
    assign unused_seed = seed;
endmodule

// File: rtl/vseq_gen_chk.sv
module vseq_gen_chk #(
    parameter int GRP_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             out_valid,
    input logic             out_ready,
    input logic [GRP_W-1:0] out_ops,
    input logic             out_last
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> out_valid && busy);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ops) && $stable(out_last));

    // R6
    finish_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !busy && !out_valid);

    // R7
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(out_valid && out_ready && out_last) |=> busy);

    // R9
    valid_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

bind vseq_gen vseq_gen_chk #(.GRP_W(SLOTS*OP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ops   (out_ops),
    .out_last  (out_last)
);

// File: tb/vseq_gen_bench.sv
module vseq_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  start_addr = '0;
    logic [63:0] start_ops = '0;
    logic [3:0]  start_mask = '0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_last, busy;
    logic [63:0] out_ops;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    vseq_gen u_vseq_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_ops(start_ops), .start_mask(start_mask), .out_valid(out_valid),
        .out_ready(out_ready), .out_ops(out_ops), .out_last(out_last), .busy(busy)
    );

    function automatic logic [63:0] pad_grp(logic [63:0] g, logic [3:0] m);
        logic [63:0] r = '0;
        for (int s = 0; s < 4; s++) if (m[s]) r[s*16 +: 16] = g[s*16 +: 16];
        return r;
    endfunction

    function automatic logic [63:0] rom_grp(logic [4:0] a);
        logic [63:0] r = '0;
        for (int s = 0; s < 4; s++)
            if (s <= int'(a % 4)) r[s*16 +: 16] = 16'h8000 | (16'(a) << 4) | 16'(s);
        return r;
    endfunction

    function automatic bit rom_end(logic [4:0] a);
        return (a % 8) == 7;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_seq(input logic [4:0] a, input logic [63:0] ops, input logic [3:0] m,
                          input int pct, input bit poke);
        bit first = 1'b1;
        bit done = 1'b0;
        logic [4:0] cur = a;
        logic [63:0] exp;
        bit elast;
        string tag;
        start = 1'b1; start_addr = a; start_ops = ops; start_mask = m; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0; start_addr = ~a; start_ops = ~ops; start_mask = ~m;
        while (!done) begin
            exp   = first ? pad_grp(ops, m) : rom_grp(cur);
            elast = !first && rom_end(cur);
            tag   = first ? "R2" : ((cur == a) ? "R3" : "R4");
            if (poke) tag = {tag, "/R8"};
            chk(out_valid == 1'b1, tag, 64'(out_valid), 64'd1);
            chk(out_ops == exp, tag, out_ops, exp);
            chk(out_last == elast, "R6", 64'(out_last), 64'(elast));
            chk(busy == 1'b1, "R7", 64'(busy), 64'd1);
            out_ready = ($urandom % 100) < pct;
            if (poke) begin
                start = 1'($urandom); start_addr = 5'($urandom);
                start_ops = {$urandom, $urandom}; start_mask = 4'($urandom);
            end
            @(negedge clk);
            if (!out_ready) chk(out_ops == exp, "R5", out_ops, exp);
            if (out_ready) begin
                if (first) first = 1'b0;
                else if (elast) done = 1'b1;
                else cur = cur + 1'b1;
            end
        end
        start = 1'b0; out_ready = 1'b0;
        chk(!out_valid && !busy, "R6", {62'd0, out_valid, busy}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!out_valid && !busy, "R1", {62'd0, out_valid, busy}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !busy, "R1", {62'd0, out_valid, busy}, 64'd0);
        // R9: ready alone in idle produces nothing
        out_ready = 1'b1;
        @(negedge clk);
        chk(!out_valid && !busy, "R9", {62'd0, out_valid, busy}, 64'd0);
        out_ready = 1'b0;
        // directed corners
        do_seq(5'd7,  64'h1111_2222_3333_4444, 4'b1111, 100, 1'b0);
        do_seq(5'd0,  64'hAAAA_BBBB_CCCC_DDDD, 4'b0000, 100, 1'b0);
        do_seq(5'd31, 64'h0102_0304_0506_0708, 4'b0101, 30, 1'b0);
        do_seq(5'd8,  64'hFFFF_EEEE_DDDD_CCCC, 4'b1010, 50, 1'b1);
        for (int i = 0; i < 40; i++)
            do_seq(5'($urandom), {$urandom, $urandom}, 4'($urandom),
                   20 + int'($urandom % 81), 1'($urandom));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule